// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects up to eight interrupt request lines and raises one interrupt output toward a processor. Requests are latched either on a rising input or by following the input level. Line 0 has the highest priority and line 7 the lowest. When the processor pulses the acknowledge strobe for one cycle, the block returns a vector equal to a programmed base plus the number of the winning line. It then records that line as in service, so that equal and lower lines stay blocked until software clears it.

Software talks to the block over a byte-wide register bus with two ports. The command port is `bus_addr`=0 and the data port is `bus_addr`=1. Writes take effect on the clock edge. Reads are combinational and have no side effects.

Configuration is an ordered sequence of words, and a small state machine steps through it:

- `ST_WAIT1` is the reset state. The controller sits idle here until the first word arrives.
- A command write with bit 4 set is the first word. It moves to `ST_WAIT2` from any state.
- `ST_WAIT2` takes the vector base on the next data write. It then moves to `ST_WAIT3` if word 1 chose cascade mode, otherwise to `ST_WAIT4` if word 1 asked for a fourth word, otherwise to `ST_READY`.
- `ST_WAIT3` stores the cascade byte. It then moves to `ST_WAIT4` if a fourth word was requested, otherwise to `ST_READY`.
- `ST_WAIT4` takes the mode byte and then moves to `ST_READY`.
- In `ST_READY`, data writes load the mask. Command writes are end-of-interrupt or register-select commands.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_req` and `vec_valid` are low and the mask reads 0. Data-port writes made before the first init word do not change the mask.
- R2: A command write with bit 4 set starts initialization from any state. In that word, bit 0 requests a fourth word, bit 1 selects single mode (0 = cascade), and bit 3 selects level triggering (0 = edge). The same write clears the mask, the in-service register, the automatic-EOI setting and all latched edge requests.
- R3: The data writes that follow init word 1 are taken in this order: the vector base; then the cascade byte, only when bit 1 of word 1 was 0 (shown on `casc_cfg`); then the mode word, only when bit 0 of word 1 was 1. The next data write after that loads the mask.
- R4: Once initialization is complete, a data write loads the mask, where bit n = 1 masks line n. A data-port read returns the mask.
- R5: In edge mode, a rising input sets its request bit on the next clock edge. The bit stays set after the input falls, and is cleared only when that line is acknowledged. Masked lines still latch.
- R6: In level mode, each request bit equals its input line in the same cycle.
- R7: `int_req` is high only after initialization, and only when some unmasked request bit has a lower line number than every set in-service bit.
- R8: Priority is fixed, with line 0 highest. An acknowledge taken while `int_req` is high makes `vec_valid` pulse in the next cycle, with `vec_out` = base + line number (mod 256).
- R9: On an acknowledge without automatic EOI, the winning line's in-service bit is set. In edge mode its request bit is cleared.
- R10: The command value 0x20 (nonspecific EOI) clears the set in-service bit with the lowest line number.
- R11: Command value 0x0A makes command-port reads return the request register, and 0x0B makes them return the in-service register. The request register is the selection after init word 1.
- R12: When bit 1 of the mode word is 1 (automatic EOI), an acknowledge clears the request but leaves the in-service register unchanged.
- R13: An acknowledge strobe while `int_req` is low produces no vector and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the port selected by `bus_addr` |
| irq_in | input | 8 | Interrupt request lines |
| int_req | output | 1 | Interrupt output to the processor |
| int_ack | input | 1 | Single-cycle acknowledge strobe |
| vec_valid | output | 1 | Vector valid, one cycle after a taken acknowledge |
| vec_out | output | 8 | Interrupt vector |
| casc_cfg | output | 8 | Stored cascade byte |

## Verification
The assertions assume that a bus write and an acknowledge do not fall in the same cycle. They also assume that an edge request never rises on a line in the same cycle that line is acknowledged, because the outcome of either overlap is not specified by the requirements. The bench keeps the two apart by giving each bus access and each acknowledge its own clock cycle. It changes `irq_in` only while no acknowledge is pending. It also holds every line low across each re-initialization, so a level already high never counts as a fresh edge.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [2:0] {
        ST_WAIT1,
        ST_WAIT2,
        ST_WAIT3,
        ST_WAIT4,
        ST_READY
    } seq_state_t;

    localparam logic [7:0] CMD_EOI     = 8'h20;
    localparam logic [7:0] CMD_SEL_IRR = 8'h0A;
    localparam logic [7:0] CMD_SEL_ISR = 8'h0B;
    localparam int         INIT_BIT    = 4;
endpackage

// File: rtl/pic_seq.sv
module pic_seq
    import pic_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic          init_pulse,
    output logic          eoi_pulse,
    output logic [DW-1:0] base,
    output logic [DW-1:0] casc,
    output logic          aeoi,
    output logic          level,
    output logic [N-1:0]  mask,
    output logic          sel_isr
);
    seq_state_t state_q, state_d;
    logic need4_q, single_q;
    logic wr_cmd, wr_dat;

    assign wr_cmd     = wr & ~addr;
    assign wr_dat     = wr & addr;
    assign init_pulse = wr_cmd & wdata[INIT_BIT];
    assign ready      = (state_q == ST_READY);
    assign eoi_pulse  = ready & wr_cmd & (wdata == CMD_EOI);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT1;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT1: state_d = ST_WAIT1;
            ST_WAIT2: if (wr_dat)
                          state_d = !single_q ? ST_WAIT3 :
                                    (need4_q ? ST_WAIT4 : ST_READY);
            ST_WAIT3: if (wr_dat) state_d = need4_q ? ST_WAIT4 : ST_READY;
            ST_WAIT4: if (wr_dat) state_d = ST_READY;
            ST_READY: state_d = ST_READY;
            default:  state_d = ST_WAIT1;
        endcase
        if (init_pulse) state_d = ST_WAIT2;
    end

    // configuration outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need4_q  <= 1'b0;
            single_q <= 1'b0;
            level    <= 1'b0;
            base     <= '0;
            casc     <= '0;
            aeoi     <= 1'b0;
            mask     <= '0;
            sel_isr  <= 1'b0;
        end else if (init_pulse) begin
            need4_q  <= wdata[0];
            single_q <= wdata[1];
            level    <= wdata[3];
            aeoi     <= 1'b0;
            mask     <= '0;
            sel_isr  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_WAIT1: ;
                ST_WAIT2: if (wr_dat) base <= wdata;
                ST_WAIT3: if (wr_dat) casc <= wdata;
                ST_WAIT4: if (wr_dat) aeoi <= wdata[1];
                ST_READY: begin
                    if (wr_dat) mask <= wdata[N-1:0];
                    if (wr_cmd && wdata == CMD_SEL_IRR) sel_isr <= 1'b0;
                    if (wr_cmd && wdata == CMD_SEL_ISR) sel_isr <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pic_req.sv
module pic_req #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic         level,
    input  logic         clear_all,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic prev_q, lat_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clear_all) begin
                prev_q <= 1'b0;
                lat_q  <= 1'b0;
            end else begin
                prev_q <= lines[g];
                lat_q  <= (lines[g] & ~prev_q) | (lat_q & ~ack_clr[g]);
            end
        end
        assign irr[g] = level ? lines[g] : lat_q;
    end
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
    assign any = |vec;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NLINES = 8,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NLINES-1:0] irq_in,
    output logic              int_req,
    input  logic              int_ack,
    output logic              vec_valid,
    output logic [DW-1:0]     vec_out,
    output logic [DW-1:0]     casc_cfg
);
    localparam int IW = $clog2(NLINES);

    logic              ready, init_pulse, eoi_pulse, aeoi, level, sel_isr;
    logic [DW-1:0]     base;
    logic [NLINES-1:0] mask, irr, isr, isr_nx, pend, win_oh;
    logic              req_any, isr_any, take;
    logic [IW-1:0]     req_idx, isr_idx;

    pic_seq #(.N(NLINES), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .ready(ready), .init_pulse(init_pulse), .eoi_pulse(eoi_pulse),
        .base(base), .casc(casc_cfg), .aeoi(aeoi), .level(level),
        .mask(mask), .sel_isr(sel_isr)
    );

    pic_req #(.N(NLINES)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .level(level),
        .clear_all(init_pulse), .ack_clr(win_oh), .irr(irr)
    );

    assign pend = irr & ~mask;

    pic_resolve #(.N(NLINES), .IW(IW)) u_res_req (.vec(pend), .any(req_any), .idx(req_idx));
    pic_resolve #(.N(NLINES), .IW(IW)) u_res_isr (.vec(isr),  .any(isr_any), .idx(isr_idx));

    assign int_req = ready & req_any & (~isr_any | (req_idx < isr_idx));
    assign take    = int_ack & int_req;
    assign win_oh  = take ? (NLINES'(1) << req_idx) : '0;

    always_comb begin
        isr_nx = isr;
        if (eoi_pulse)     isr_nx = isr_nx & (isr_nx - 1'b1);
        if (take && !aeoi) isr_nx = isr_nx | win_oh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || init_pulse) isr <= '0;
        else                      isr <= isr_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= take;
            if (take) vec_out <= base + DW'(req_idx);
        end
    end

    assign bus_rdata = bus_addr ? DW'(mask) : (sel_isr ? DW'(isr) : DW'(irr));
endmodule

module pic_chk #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic          bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          int_req,
    input logic          int_ack,
    input logic          vec_valid,
    input logic          ready,
    input logic          aeoi,
    input logic [N-1:0]  mask,
    input logic [N-1:0]  isr
);
    a_r7_int_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ready);

    a_r8_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req) |=> vec_valid);

    a_r13_no_vec_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_ack && int_req) |=> !vec_valid);

    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[4]) |=> (mask == '0 && isr == '0 && !ready));

    a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bus_wr && bus_addr) |=> (mask == $past(bus_wdata[N-1:0])));

    a_r10_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && bus_wr && !bus_addr && bus_wdata == 8'h20 && !int_ack && isr != '0)
        |=> ($countones(isr) + 1 == $countones($past(isr))));

    a_r12_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && aeoi && int_ack && int_req && !bus_wr) |=> (isr == $past(isr)));
endmodule

bind prio_irq_ctrl pic_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .int_req(int_req), .int_ack(int_ack),
    .vec_valid(vec_valid), .ready(ready), .aeoi(aeoi), .mask(mask), .isr(isr)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       int_req;
    logic       int_ack = 1'b0;
    logic       vec_valid;
    logic [7:0] vec_out;
    logic [7:0] casc_cfg;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rv;

    always #4 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_req(int_req), .int_ack(int_ack), .vec_valid(vec_valid),
        .vec_out(vec_out), .casc_cfg(casc_cfg)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // driver: push expected vector, then pulse acknowledge
    task automatic do_ack(input logic [7:0] exp);
        exp_q.push_back(exp);
        @(negedge clk); int_ack = 1'b1;
        @(negedge clk); int_ack = 1'b0;
        #1;
    endtask

    // monitor: compare each produced vector against the scoreboard
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8: actual vector %h expected none", vec_out);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                if (vec_out !== e) begin
                    n_bad++;
                    $display("FAIL R8: actual vector %h expected %h", vec_out, e);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 int_req at reset", {7'b0, int_req}, 8'h00);
        chk("R1 vec_valid at reset", {7'b0, vec_valid}, 8'h00);
        rd(1'b1, rv); chk("R1 mask at reset", rv, 8'h00);
        wr(1'b1, 8'h55);
        rd(1'b1, rv); chk("R1 data write ignored before init", rv, 8'h00);

        // cascade master, edge mode, fourth word requested
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        chk("R3 cascade byte stored", casc_cfg, 8'h04);
        rd(1'b1, rv); chk("R3 mask untouched by init words", rv, 8'h00);
        rd(1'b0, rv); chk("R11 default read is request reg", rv, 8'h00);

        wr(1'b1, 8'hF0);
        rd(1'b1, rv); chk("R4 mask readback", rv, 8'hF0);

        @(negedge clk); irq_in = 8'h20;
        @(negedge clk); irq_in = 8'h00; #1;
        chk("R7 masked line gives no int_req", {7'b0, int_req}, 8'h00);
        rd(1'b0, rv); chk("R5 masked line still latched", rv, 8'h20);
        @(negedge clk); irq_in = 8'h0A;
        @(negedge clk); irq_in = 8'h00; #1;
        chk("R5 request held after input falls", {7'b0, int_req}, 8'h01);
        rd(1'b0, rv); chk("R5 request register", rv, 8'h2A);

        do_ack(8'h21);
        wr(1'b0, 8'h0B);
        rd(1'b0, rv); chk("R9 line 1 in service", rv, 8'h02);
        wr(1'b0, 8'h0A);
        rd(1'b0, rv); chk("R9 line 1 request cleared", rv, 8'h28);
        chk("R7 lower line blocked by service", {7'b0, int_req}, 8'h00);

        @(negedge clk); int_ack = 1'b1;
        @(negedge clk); int_ack = 1'b0; #1;
        chk("R13 no vector without int_req", {7'b0, vec_valid}, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, rv); chk("R13 service unchanged", rv, 8'h02);

        wr(1'b0, 8'h20); #1;
        rd(1'b0, rv); chk("R10 EOI clears line 1", rv, 8'h00);
        chk("R7 int_req after EOI", {7'b0, int_req}, 8'h01);
        do_ack(8'h23);
        @(negedge clk); irq_in = 8'h01;
        @(negedge clk); irq_in = 8'h00; #1;
        chk("R7 higher line nests", {7'b0, int_req}, 8'h01);
        do_ack(8'h20);
        rd(1'b0, rv); chk("R9 two lines in service", rv, 8'h09);
        wr(1'b0, 8'h20);
        rd(1'b0, rv); chk("R10 EOI clears lowest line", rv, 8'h08);
        wr(1'b0, 8'h20);
        rd(1'b0, rv); chk("R10 second EOI", rv, 8'h00);

        // single, level mode, no third or fourth word
        wr(1'b0, 8'h1A);
        rd(1'b1, rv); chk("R2 init clears mask", rv, 8'h00);
        wr(1'b1, 8'hF8);
        wr(1'b1, 8'h80);
        rd(1'b1, rv); chk("R3 skipped words, next write is mask", rv, 8'h80);
        @(negedge clk); irq_in = 8'h40; #1;
        chk("R6 level line drives int_req", {7'b0, int_req}, 8'h01);
        rd(1'b0, rv); chk("R6 request follows input", rv, 8'h40);
        @(negedge clk); irq_in = 8'h00; #1;
        chk("R6 int_req drops with input", {7'b0, int_req}, 8'h00);
        @(negedge clk); irq_in = 8'h80; #1;
        chk("R4 masked level line", {7'b0, int_req}, 8'h00);
        @(negedge clk); irq_in = 8'h40;
        do_ack(8'hFE);
        chk("R9 level line blocked while in service", {7'b0, int_req}, 8'h00);
        @(negedge clk); irq_in = 8'h00;
        wr(1'b0, 8'h20);

        // restart mid-sequence, then single with automatic EOI
        wr(1'b0, 8'h11); wr(1'b1, 8'h50);
        wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h03);
        rd(1'b1, rv); chk("R2 restart leaves mask clear", rv, 8'h00);
        rd(1'b0, rv); chk("R2 latched requests cleared", rv, 8'h00);
        wr(1'b1, 8'h00);
        @(negedge clk); irq_in = 8'h10;
        @(negedge clk); irq_in = 8'h00;
        do_ack(8'h44);
        wr(1'b0, 8'h0B);
        rd(1'b0, rv); chk("R12 auto EOI leaves service empty", rv, 8'h00);
        chk("R12 request consumed", {7'b0, int_req}, 8'h00);

        repeat (2) @(negedge clk);
        chk("R8 all vectors produced", 8'(exp_q.size()), 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule